// File: doc/BRIEF.md
# Cell Queue Manager with Congestion Thresholds

This block keeps the bookkeeping for one circular cell queue that lives in external memory. Memory is addressed in whole 64-byte cells, so every address the block handles is a 19-bit cell index (byte-address bits 24 down to 6). Software sets the queue's first and last cell, loads the write and read pointers, and programs two fill thresholds and their enable bits through a small write-only configuration port. Pointers, bounds and fill count can only be written while the queue is disabled.

Once enabled, an arrival port asks to enqueue one cell and carries that cell's loss-priority bit. A departure port asks to dequeue one cell. For each request the block answers in the same cycle. It gives the cell address to use, an accept or drop decision for arrivals, and a forward-congestion mark for departures. It then advances the pointers, wrapping from the last cell back to the first, and updates a running fill count. Arrivals are refused when the queue is full. Low-priority arrivals are discarded above one threshold, and departures are marked above the other.

Top module: `cellq_mgr`

## Requirements
- R1: After reset the queue is disabled, both cell pointers and the fill level read zero, and both thresholds and both enables are zero.
- R2: A control write (field 6: bit 0 enable, bit 1 mark enable, bit 2 discard enable) turns the queue on only when last cell minus first cell is at least three (four or more cells). Otherwise q_enabled stays 0.
- R3: Writes to the first cell (field 0), last cell (field 1), write pointer (field 2), read pointer (field 3) and fill level (field 7) take effect only while the queue is disabled. While it is enabled they leave wr_cell, rd_cell and fill_level unchanged. Threshold writes (mark field 4, discard field 5) take effect at any time.
- R4: An accepted arrival raises enq_ok and presents the current write pointer on wr_cell in the same cycle. The pointer then advances by one, and after the last cell it wraps to the first.
- R5: An accepted departure raises deq_ok and presents the current read pointer on rd_cell in the same cycle. The pointer then advances by one with the same wrap.
- R6: The fill level rises by one per accepted arrival and falls by one per accepted departure. When both are accepted in the same cycle it stays unchanged.
- R7: When the fill level equals capacity (last minus first plus one), an arrival raises enq_drop_full, whatever its loss-priority bit. It is not stored, and enq_drop_clp stays 0.
- R8: A departure request at fill level zero raises deq_underflow for that cycle. Neither pointer moves and the fill level is unchanged.
- R9: When discard is enabled and the fill level is at or above the discard threshold, a non-full arrival with its loss-priority bit set raises enq_drop_clp and is not stored. Arrivals with the bit clear, or any arrival while discard is disabled, are accepted.
- R10: deq_mark is raised with an accepted departure exactly when marking is enabled and the fill level before the departure is at or above the mark threshold.
- R11: While disabled, no request produces enq_ok, deq_ok, a drop or an underflow, and the pointers and fill level hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Field select for the write |
| cfg_wdata | input | 19 | Write data (cell index, threshold or control bits) |
| enq_req | input | 1 | Arrival request |
| enq_clp | input | 1 | Loss-priority bit of the arriving cell |
| deq_req | input | 1 | Departure request |
| q_enabled | output | 1 | Queue is enabled |
| wr_cell | output | 19 | Current write pointer (arrival cell address) |
| rd_cell | output | 19 | Current read pointer (departure cell address) |
| fill_level | output | 20 | Cells currently held |
| enq_ok | output | 1 | Arrival accepted |
| enq_drop_clp | output | 1 | Arrival discarded by loss-priority threshold |
| enq_drop_full | output | 1 | Arrival discarded because queue is full |
| deq_ok | output | 1 | Departure accepted |
| deq_mark | output | 1 | Departing cell carries a forward-congestion mark |
| deq_underflow | output | 1 | Departure requested while empty |

## Verification
An arrival and a departure can land in the same cycle. The arrival decision and the departure decision then both read the same fill level, and the counter must net to zero. The vector table drives simultaneous requests at a mid fill and again at full. At full the arrival must report the overflow drop while the departure is still accepted and marked, and the fill level must end one below capacity. The bench checks flags, both cell addresses and the fill level against a model kept from the requirements.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
  // configuration field select codes
  typedef enum logic [2:0] {
    FLD_BASE = 3'd0,
    FLD_LAST = 3'd1,
    FLD_WPTR = 3'd2,
    FLD_RPTR = 3'd3,
    FLD_MARK = 3'd4,
    FLD_DISC = 3'd5,
    FLD_CTRL = 3'd6,
    FLD_FILL = 3'd7
  } cfg_field_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MARK_BIT = 1;
  localparam int CTRL_DISC_BIT = 2;
  localparam int MIN_CELLS     = 4;
endpackage

// File: rtl/cellq_cfg.sv
module cellq_cfg
  import cellq_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_cell,
  output logic [AW-1:0] last_cell,
  output logic [AW-1:0] mark_thr,
  output logic [AW-1:0] disc_thr,
  output logic          q_en,
  output logic          mark_en,
  output logic          disc_en,
  output logic          ld_wptr,
  output logic          ld_rptr,
  output logic          ld_fill
);
  localparam int SPAN_MIN = MIN_CELLS - 1;

  logic [AW-1:0] base_q, base_d, last_q, last_d;
  logic [AW-1:0] mark_q, mark_d, disc_q, disc_d;
  logic          en_q, en_d, men_q, men_d, den_q, den_d;
  logic          geom_ok;
  cfg_field_e    fld;

  assign fld     = cfg_field_e'(sel);
  assign geom_ok = {1'b0, last_q} >= ({1'b0, base_q} + (AW+1)'(SPAN_MIN));

  always_comb begin
    base_d = base_q;
    last_d = last_q;
    mark_d = mark_q;
    disc_d = disc_q;
    en_d   = en_q;
    men_d  = men_q;
    den_d  = den_q;
    if (we) begin
      unique case (fld)
        FLD_BASE: if (!en_q) base_d = wdata;
        FLD_LAST: if (!en_q) last_d = wdata;
        FLD_MARK: mark_d = wdata;
        FLD_DISC: disc_d = wdata;
        FLD_CTRL: begin
          en_d  = wdata[CTRL_EN_BIT] && geom_ok;
          men_d = wdata[CTRL_MARK_BIT];
          den_d = wdata[CTRL_DISC_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '0;
      mark_q <= '0;
      disc_q <= '0;
      en_q   <= 1'b0;
      men_q  <= 1'b0;
      den_q  <= 1'b0;
    end else if (we) begin
      base_q <= base_d;
      last_q <= last_d;
      mark_q <= mark_d;
      disc_q <= disc_d;
      en_q   <= en_d;
      men_q  <= men_d;
      den_q  <= den_d;
    end
  end

  assign ld_wptr   = we && !en_q && (fld == FLD_WPTR);
  assign ld_rptr   = we && !en_q && (fld == FLD_RPTR);
  assign ld_fill   = we && !en_q && (fld == FLD_FILL);
  assign base_cell = base_q;
  assign last_cell = last_q;
  assign mark_thr  = mark_q;
  assign disc_thr  = disc_q;
  assign q_en      = en_q;
  assign mark_en   = men_q;
  assign disc_en   = den_q;

  // R2: the queue never turns on over a region smaller than four cells
  assert_enable_geom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_en && !$past(q_en)) |-> ({1'b0, last_cell} >= {1'b0, base_cell} + (AW+1)'(SPAN_MIN)));

  // R3: bounds hold while enabled
  assert_bounds_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(q_en) |-> ($stable(base_cell) && $stable(last_cell)));
endmodule

// File: rtl/cellq_ptr.sv
module cellq_ptr #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          adv,
  input  logic [AW-1:0] base_cell,
  input  logic [AW-1:0] last_cell,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          at_last;

  assign at_last = (ptr_q == last_cell);

  always_comb begin
    ptr_d = ptr_q;
    if (ld)       ptr_d = ld_val;
    else if (adv) ptr_d = at_last ? base_cell : ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr_q <= '0;
    else if (ld || adv)  ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R8/R11: without advance or load the pointer holds
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv) |=> $stable(ptr));

  // R4/R5: leaving the last cell lands on the first cell
  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && ptr == last_cell) |=> (ptr == $past(base_cell)));
endmodule

// File: rtl/cellq_fill.sv
module cellq_fill #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW:0]   ld_val,
  input  logic          inc,
  input  logic          dec,
  input  logic [AW-1:0] base_cell,
  input  logic [AW-1:0] last_cell,
  input  logic [AW-1:0] mark_thr,
  input  logic [AW-1:0] disc_thr,
  output logic [AW:0]   fill,
  output logic          full,
  output logic          empty,
  output logic          over_mark,
  output logic          over_disc
);
  localparam int FW = AW + 1;

  logic [FW-1:0] fill_q, fill_d, cap;

  assign cap = {1'b0, last_cell} - {1'b0, base_cell} + FW'(1);

  always_comb begin
    fill_d = fill_q;
    if (ld)               fill_d = ld_val;
    else if (inc && !dec) fill_d = fill_q + FW'(1);
    else if (dec && !inc) fill_d = fill_q - FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 fill_q <= '0;
    else if (ld || inc || dec)  fill_q <= fill_d;
  end

  assign fill      = fill_q;
  assign full      = (fill_q >= cap);
  assign empty     = (fill_q == '0);
  assign over_mark = (fill_q >= {1'b0, mark_thr});
  assign over_disc = (fill_q >= {1'b0, disc_thr});

  // R6: a lone accepted arrival adds exactly one cell
  assert_fill_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !ld) |=> (fill == $past(fill) + FW'(1)));

  // R6: paired arrival and departure net to zero
  assert_fill_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !ld) |=> $stable(fill));
endmodule

// File: rtl/cellq_mgr.sv
module cellq_mgr
  import cellq_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          enq_req,
  input  logic          enq_clp,
  input  logic          deq_req,
  output logic          q_enabled,
  output logic [AW-1:0] wr_cell,
  output logic [AW-1:0] rd_cell,
  output logic [AW:0]   fill_level,
  output logic          enq_ok,
  output logic          enq_drop_clp,
  output logic          enq_drop_full,
  output logic          deq_ok,
  output logic          deq_mark,
  output logic          deq_underflow
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rst_sync_q[SYNC_STAGES-1];

  logic [AW-1:0] base_cell, last_cell, mark_thr, disc_thr;
  logic          q_en, mark_en, disc_en, ld_wptr, ld_rptr, ld_fill;
  logic          full, empty, over_mark, over_disc;
  logic          enq_live, deq_live, clp_hit;

  cellq_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_sn), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_cell(base_cell), .last_cell(last_cell), .mark_thr(mark_thr),
    .disc_thr(disc_thr), .q_en(q_en), .mark_en(mark_en), .disc_en(disc_en),
    .ld_wptr(ld_wptr), .ld_rptr(ld_rptr), .ld_fill(ld_fill)
  );

  // arrival/departure decisions
  always_comb begin
    enq_live      = q_en && enq_req;
    deq_live      = q_en && deq_req;
    clp_hit       = disc_en && over_disc && enq_clp;
    enq_drop_full = enq_live && full;
    enq_drop_clp  = enq_live && !full && clp_hit;
    enq_ok        = enq_live && !full && !clp_hit;
    deq_ok        = deq_live && !empty;
    deq_underflow = deq_live && empty;
    deq_mark      = deq_ok && mark_en && over_mark;
  end

  cellq_ptr #(.AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_sn), .ld(ld_wptr), .ld_val(cfg_wdata), .adv(enq_ok),
    .base_cell(base_cell), .last_cell(last_cell), .ptr(wr_cell)
  );

  cellq_ptr #(.AW(AW)) u_rptr (
    .clk(clk), .rst_n(rst_sn), .ld(ld_rptr), .ld_val(cfg_wdata), .adv(deq_ok),
    .base_cell(base_cell), .last_cell(last_cell), .ptr(rd_cell)
  );

  cellq_fill #(.AW(AW)) u_fill (
    .clk(clk), .rst_n(rst_sn), .ld(ld_fill), .ld_val({1'b0, cfg_wdata}),
    .inc(enq_ok), .dec(deq_ok), .base_cell(base_cell), .last_cell(last_cell),
    .mark_thr(mark_thr), .disc_thr(disc_thr), .fill(fill_level), .full(full),
    .empty(empty), .over_mark(over_mark), .over_disc(over_disc)
  );

  assign q_enabled = q_en;

  // R7/R9: one arrival outcome at most
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({enq_ok, enq_drop_clp, enq_drop_full}));

  // R10: marks only ride on accepted departures
  assert_mark_on_dep_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    deq_mark |-> deq_ok);

  // R8: an underflow leaves the read side untouched
  assert_underflow_hold_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    deq_underflow |=> ($stable(rd_cell) && (fill_level <= $past(fill_level) + 1'b1)));

  // R11: disabled queue holds its fill level
  assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    (!q_enabled && !cfg_we) |=> $stable(fill_level));
endmodule

// File: tb/tb_cellq_mgr.sv
module tb_cellq_mgr;
  localparam int AW = 19;
  localparam int NV = 16;
  // {enq, clp, deq, ok, drop_clp, drop_full, deq_ok, mark, underflow, fill[2:0]}
  localparam logic [11:0] VEC [NV] = '{
    12'b001_000001_000, 12'b110_100000_001, 12'b110_100000_010,
    12'b110_010000_010, 12'b100_100000_011, 12'b001_000110_010,
    12'b101_100100_010, 12'b100_100000_011, 12'b100_100000_100,
    12'b100_001000_100, 12'b110_001000_100, 12'b101_001110_011,
    12'b001_000110_010, 12'b001_000100_001, 12'b001_000100_000,
    12'b001_000001_000
  };
  localparam int QBASE = 10;
  localparam int QLAST = 13;

  logic clk, rst_n, cfg_we, enq_req, enq_clp, deq_req;
  logic [2:0] cfg_sel;
  logic [AW-1:0] cfg_wdata, wr_cell, rd_cell;
  logic [AW:0] fill_level;
  logic q_enabled, enq_ok, enq_drop_clp, enq_drop_full, deq_ok, deq_mark, deq_underflow;
  int checks, fails;
  bit done;

  cellq_mgr #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .enq_req(enq_req), .enq_clp(enq_clp), .deq_req(deq_req), .q_enabled(q_enabled),
    .wr_cell(wr_cell), .rd_cell(rd_cell), .fill_level(fill_level), .enq_ok(enq_ok),
    .enq_drop_clp(enq_drop_clp), .enq_drop_full(enq_drop_full), .deq_ok(deq_ok),
    .deq_mark(deq_mark), .deq_underflow(deq_underflow)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = AW'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic e, input logic c, input logic d);
    @(negedge clk);
    enq_req = e; enq_clp = c; deq_req = d;
    #2;
  endtask

  task automatic release_ops();
    @(posedge clk); #1;
    enq_req = 1'b0; enq_clp = 1'b0; deq_req = 1'b0;
  endtask

  function automatic int nxt(input int p);
    return (p == QLAST) ? QBASE : p + 1;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ew, er;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    enq_req = 1'b0; enq_clp = 1'b0; deq_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 enabled", q_enabled, 0);
    chk("R1 wr_cell", wr_cell, 0);
    chk("R1 rd_cell", rd_cell, 0);
    chk("R1 fill", fill_level, 0);

    // R1: reset thresholds/enables: a disabled queue accepts nothing
    drive(1'b1, 1'b0, 1'b1);
    chk("R1 enq_ok while off", enq_ok, 0);
    release_ops();

    // setup: four-cell queue, discard thr 2, mark thr 3, all enables
    cfg_write(3'd0, QBASE);
    cfg_write(3'd1, QLAST);
    cfg_write(3'd2, QBASE);
    cfg_write(3'd3, QBASE);
    cfg_write(3'd4, 3);
    cfg_write(3'd5, 2);
    cfg_write(3'd6, 7);
    chk("R2 enable valid", q_enabled, 1);

    ew = QBASE; er = QBASE;
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      drive(v[11], v[10], v[9]);
      chk("R4 R9 enq_ok", enq_ok, v[8]);
      chk("R9 drop_clp", enq_drop_clp, v[7]);
      chk("R7 drop_full", enq_drop_full, v[6]);
      chk("R5 deq_ok", deq_ok, v[5]);
      chk("R10 mark", deq_mark, v[4]);
      chk("R8 underflow", deq_underflow, v[3]);
      if (v[8]) chk("R4 wr addr", wr_cell, ew);
      if (v[5]) chk("R5 rd addr", rd_cell, er);
      release_ops();
      if (v[8]) ew = nxt(ew);
      if (v[5]) er = nxt(er);
      chk("R6 fill", fill_level, v[2:0]);
      chk("R4 wr ptr", wr_cell, ew);
      chk("R5 rd ptr", rd_cell, er);
    end

    // R9 discard disabled, R10 mark disabled, thresholds written while on
    cfg_write(3'd4, 0);
    cfg_write(3'd5, 0);
    cfg_write(3'd6, 1);
    drive(1'b1, 1'b1, 1'b0);
    chk("R9 clp accepted when off", enq_ok, 1);
    release_ops();
    drive(1'b0, 1'b0, 1'b1);
    chk("R10 no mark when off", deq_mark, 0);
    chk("R10 deq ok", deq_ok, 1);
    release_ops();
    ew = nxt(ew); er = nxt(er);

    // R3 pointer/fill writes ignored while enabled
    cfg_write(3'd2, 5);
    cfg_write(3'd7, 3);
    chk("R3 wptr locked", wr_cell, ew);
    chk("R3 fill locked", fill_level, 0);

    // R11 disabled: no outcome, state held
    cfg_write(3'd6, 0);
    drive(1'b1, 1'b1, 1'b1);
    chk("R11 enq_ok", enq_ok, 0);
    chk("R11 drops", {enq_drop_clp, enq_drop_full}, 0);
    chk("R11 deq/underflow", {deq_ok, deq_underflow}, 0);
    release_ops();
    chk("R11 wr hold", wr_cell, ew);
    chk("R11 rd hold", rd_cell, er);
    chk("R11 fill hold", fill_level, 0);

    // R3 writes accepted while disabled
    cfg_write(3'd2, 5);
    cfg_write(3'd7, 2);
    chk("R3 wptr loaded", wr_cell, 5);
    chk("R3 fill loaded", fill_level, 2);

    // R2 three-cell region refused, four-cell accepted
    cfg_write(3'd0, 20);
    cfg_write(3'd1, 22);
    cfg_write(3'd6, 1);
    chk("R2 refuse small", q_enabled, 0);
    cfg_write(3'd1, 23);
    cfg_write(3'd6, 1);
    chk("R2 accept four", q_enabled, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule